// File: doc/BRIEF.md
# Hot-Plug Slot Command Executor

This block is the command engine of a hot-plug controller for a parallel expansion bus. Software writes one 16-bit command word that holds an opcode and a target slot. The engine raises a busy flag and holds it for a fixed number of cycles. When that time is up it checks the command against the slot latch sensors, the configured slot count and the programming-interface revision. If the command is legal it applies the change to the per-slot state, the power indicator, the attention indicator or the bus-wide speed/mode. It then drops busy, reports a one-hot error reason and raises a completion event. Software clears the event by writing 1 to it.

A slot operation can change the slot state and both indicators in one write, because each has its own 2-bit field. Other opcode ranges select a bus speed/mode, either from the basic table or from the extended table that only revision 2 accepts. Two more opcodes act on every slot at once.

Top module: `hpcmd_engine`

## Requirements
- R1: After reset busy, err_code and cmd_done are 0 and bus_mode is 0. Every slot reads state 2'b11 (disabled), and both of its indicators read 2'b11 (off).
- R2: A cmd_wr seen while idle is accepted. busy reads 1 from the next cycle for exactly EXEC_CYC cycles, and every visible effect of the command appears in the cycle in which busy returns to 0.
- R3: A cmd_wr seen while busy is 1 has no effect. The running command completes with its own result.
- R4: The command word holds the opcode in bits [7:0] and a one-based target slot in bits [15:8]. Target 1 is slot index 0. For opcodes 0x00–0x3F, bits [1:0] set the slot state (01 power-only, 10 enabled, 11 disabled), bits [3:2] set the power indicator and bits [5:4] set the attention indicator (01 on, 10 blink, 11 off). A field of 00 leaves its item unchanged. Only the target slot changes.
- R5: A slot opcode whose target is 0 or above NSLOT ends with err_code 3'b010 (invalid command) and changes nothing.
- R6: A slot opcode whose state field is 01 or 10, aimed at a slot whose latch_open bit is 1, ends with err_code 3'b001 (switch open) and changes no field at all. State 11 and indicator-only commands go through while the latch is open.
- R7: Opcodes 0x40–0x44 set bus_mode to opcode minus 0x40. Opcodes 0x45–0x47 end with err_code 3'b010. Bus-wide opcodes ignore the target field.
- R8: Opcode 0x48 sets the state of every slot whose latch is closed to 01. Opcode 0x49 sets it to 10. Slots whose latch is open keep their state, the indicators do not change, and err_code is 0.
- R9: Opcodes 0x50–0x5D set bus_mode to opcode bits [3:0] when pi_rev2 is 1. When pi_rev2 is 0 they end with err_code 3'b100 (speed/mode invalid) and bus_mode is left unchanged. Opcodes 0x5E and 0x5F end with err_code 3'b010.
- R10: Opcodes 0x4A–0x4F and 0x60–0xFF end with err_code 3'b010 and change nothing.
- R11: cmd_done becomes 1 in the cycle busy falls and holds until evt_clr is 1 at a clock edge. If the set and the clear fall on the same edge, the set wins. err_code reads 0 while a command runs, holds the last result afterwards, and never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 16 | Command word: target slot [15:8], opcode [7:0] |
| evt_clr | input | 1 | Write-1-to-clear for the completion event |
| latch_open | input | NSLOT | Per-slot retention latch sensor, 1 = open |
| pi_rev2 | input | 1 | 1 = programming-interface revision 2 |
| busy | output | 1 | A command is executing |
| err_code | output | 3 | One-hot reason the last command failed |
| cmd_done | output | 1 | Completion event |
| slot_state | output | 2*NSLOT | Slot state, 2 bits per slot |
| pwr_ind | output | 2*NSLOT | Power indicator, 2 bits per slot |
| attn_ind | output | 2*NSLOT | Attention indicator, 2 bits per slot |
| bus_mode | output | 4 | Current bus speed/mode code |

## Verification
A wrong countdown shows up at once as busy falling one cycle early or late. A mis-latched command word shows up in the same completion cycle as wrong slot fields or a wrong error bit. Decode faults cannot stay hidden for long. Every opcode is swept against in-range and out-of-range targets, under two latch patterns and both interface revisions, and the bench compares all slot fields, bus_mode, err_code and cmd_done against its model after each command. A lost event or a clear that wins over a set appears in the cycle right after completion.

// File: rtl/hpcmd_pkg.sv
`timescale 1ns/1ps
package hpcmd_pkg;

    typedef enum logic [2:0] {
        K_NONE    = 3'd0,
        K_SLOT    = 3'd1,
        K_ALL_PWR = 3'd2,
        K_ALL_EN  = 3'd3,
        K_BUS     = 3'd4
    } op_kind_e;

    localparam logic [2:0] ERR_OK    = 3'b000;
    localparam logic [2:0] ERR_LATCH = 3'b001;
    localparam logic [2:0] ERR_CMD   = 3'b010;
    localparam logic [2:0] ERR_MODE  = 3'b100;

    localparam logic [1:0] ST_PWR_ONLY = 2'b01;
    localparam logic [1:0] ST_ENABLED  = 2'b10;
    localparam logic [1:0] ST_DISABLED = 2'b11;
    localparam logic [1:0] IND_OFF     = 2'b11;

    typedef struct packed {
        logic [1:0] st;
        logic [1:0] pwr;
        logic [1:0] attn;
    } slot_t;

endpackage

// File: rtl/hpcmd_decode.sv
`timescale 1ns/1ps
module hpcmd_decode
    import hpcmd_pkg::*;
#(
    parameter int NSLOT = 4,
    localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic [7:0]       op_i,
    input  logic [7:0]       tgt_i,
    input  logic [NSLOT-1:0] latch_open_i,
    input  logic             pi_rev2_i,
    output op_kind_e         kind_o,
    output logic [2:0]       err_o,
    output logic [SW-1:0]    idx_o,
    output logic [3:0]       mode_o
);

    logic wants_power;

    always_comb begin
        kind_o      = K_NONE;
        err_o       = ERR_OK;
        idx_o       = '0;
        mode_o      = '0;
        wants_power = (op_i[1:0] == ST_PWR_ONLY) || (op_i[1:0] == ST_ENABLED);
        if (op_i[7:6] == 2'b00) begin
            if (tgt_i == 8'd0 || tgt_i > 8'(NSLOT)) begin
                err_o = ERR_CMD;
            end else begin
                idx_o = SW'(tgt_i - 8'd1);
                if (wants_power && latch_open_i[idx_o]) begin
                    err_o = ERR_LATCH;
                end else begin
                    kind_o = K_SLOT;
                end
            end
        end else if (op_i[7:3] == 5'b01000) begin
            if (op_i[2:0] <= 3'd4) begin
                kind_o = K_BUS;
                mode_o = {1'b0, op_i[2:0]};
            end else begin
                err_o = ERR_CMD;
            end
        end else if (op_i == 8'h48) begin
            kind_o = K_ALL_PWR;
        end else if (op_i == 8'h49) begin
            kind_o = K_ALL_EN;
        end else if (op_i[7:4] == 4'h5) begin
            if (op_i[3:0] >= 4'hE) begin
                err_o = ERR_CMD;
            end else if (!pi_rev2_i) begin
                err_o = ERR_MODE;
            end else begin
                kind_o = K_BUS;
                mode_o = op_i[3:0];
            end
        end else begin
            err_o = ERR_CMD;
        end
    end

endmodule

// File: rtl/hpcmd_slot_bank.sv
`timescale 1ns/1ps
module hpcmd_slot_bank
    import hpcmd_pkg::*;
#(
    parameter int NSLOT = 4,
    localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               apply_i,
    input  op_kind_e           kind_i,
    input  logic [SW-1:0]      idx_i,
    input  logic [5:0]         fields_i,
    input  logic [NSLOT-1:0]   latch_open_i,
    output logic [2*NSLOT-1:0] st_o,
    output logic [2*NSLOT-1:0] pwr_o,
    output logic [2*NSLOT-1:0] attn_o
);

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        slot_t slot_q, slot_d;

        always_comb begin
            slot_d = slot_q;
            if (apply_i) begin
                unique case (kind_i)
                    K_SLOT: begin
                        if (idx_i == SW'(i)) begin
                            if (fields_i[1:0] != 2'b00) slot_d.st   = fields_i[1:0];
                            if (fields_i[3:2] != 2'b00) slot_d.pwr  = fields_i[3:2];
                            if (fields_i[5:4] != 2'b00) slot_d.attn = fields_i[5:4];
                        end
                    end
                    K_ALL_PWR: if (!latch_open_i[i]) slot_d.st = ST_PWR_ONLY;
                    K_ALL_EN:  if (!latch_open_i[i]) slot_d.st = ST_ENABLED;
                    default: ;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '{st: ST_DISABLED, pwr: IND_OFF, attn: IND_OFF};
            end else begin
                slot_q <= slot_d;
            end
        end

        assign st_o[2*i +: 2]   = slot_q.st;
        assign pwr_o[2*i +: 2]  = slot_q.pwr;
        assign attn_o[2*i +: 2] = slot_q.attn;

        AST_STATE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
            slot_q.st != 2'b00); // R4
    end

endmodule

// File: rtl/hpcmd_engine.sv
`timescale 1ns/1ps
module hpcmd_engine
    import hpcmd_pkg::*;
#(
    parameter int NSLOT    = 4,
    parameter int EXEC_CYC = 8,
    localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int CW = (EXEC_CYC > 1) ? $clog2(EXEC_CYC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic [15:0]        cmd_wdata,
    input  logic               evt_clr,
    input  logic [NSLOT-1:0]   latch_open,
    input  logic               pi_rev2,
    output logic               busy,
    output logic [2:0]         err_code,
    output logic               cmd_done,
    output logic [2*NSLOT-1:0] slot_state,
    output logic [2*NSLOT-1:0] pwr_ind,
    output logic [2*NSLOT-1:0] attn_ind,
    output logic [3:0]         bus_mode
);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [15:0]   cmd;
        logic [2:0]    err;
        logic          evt;
        logic [3:0]    mode;
    } ctl_t;

    ctl_t          ctl_q, ctl_d;
    op_kind_e      dec_kind;
    logic [2:0]    dec_err;
    logic [SW-1:0] dec_idx;
    logic [3:0]    dec_mode;
    logic          finish;

    hpcmd_decode #(.NSLOT(NSLOT)) decode_i (
        .op_i         (ctl_q.cmd[7:0]),
        .tgt_i        (ctl_q.cmd[15:8]),
        .latch_open_i (latch_open),
        .pi_rev2_i    (pi_rev2),
        .kind_o       (dec_kind),
        .err_o        (dec_err),
        .idx_o        (dec_idx),
        .mode_o       (dec_mode)
    );

    always_comb begin
        ctl_d  = ctl_q;
        finish = ctl_q.busy && (ctl_q.cnt == '0);
        if (!ctl_q.busy) begin
            if (cmd_wr) begin
                ctl_d.busy = 1'b1;
                ctl_d.cnt  = CW'(EXEC_CYC - 1);
                ctl_d.cmd  = cmd_wdata;
                ctl_d.err  = ERR_OK;
            end
        end else if (!finish) begin
            ctl_d.cnt = ctl_q.cnt - 1'b1;
        end else begin
            ctl_d.busy = 1'b0;
            ctl_d.err  = dec_err;
            if (dec_kind == K_BUS) ctl_d.mode = dec_mode;
        end
        if (evt_clr) ctl_d.evt = 1'b0;
        if (finish)  ctl_d.evt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    hpcmd_slot_bank #(.NSLOT(NSLOT)) bank_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .apply_i      (finish),
        .kind_i       (dec_kind),
        .idx_i        (dec_idx),
        .fields_i     (ctl_q.cmd[5:0]),
        .latch_open_i (latch_open),
        .st_o         (slot_state),
        .pwr_o        (pwr_ind),
        .attn_o       (attn_ind)
    );

    assign busy     = ctl_q.busy;
    assign err_code = ctl_q.err;
    assign cmd_done = ctl_q.evt;
    assign bus_mode = ctl_q.mode;

    AST_IGNORE_BUSY_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> $stable(ctl_q.cmd)); // R3
    AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> cmd_done); // R11
    AST_ERR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(err_code)); // R11
    AST_ERR_CLEAR_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (err_code == ERR_OK)); // R11
    AST_SLOTS_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({slot_state, pwr_ind, attn_ind}) |-> $fell(busy)); // R2
    AST_REJECT_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && err_code != ERR_OK) |-> $stable({slot_state, pwr_ind, attn_ind})); // R5
    AST_MODE_ON_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bus_mode) |-> ($fell(busy) && err_code == ERR_OK)); // R9

endmodule

// File: tb/hpcmd_engine_tb_top.sv
`timescale 1ns/1ps
module hpcmd_engine_tb_top;

    localparam int NS = 4;
    localparam int EX = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_wr = 1'b0;
    logic [15:0]     cmd_wdata = '0;
    logic            evt_clr = 1'b0;
    logic [NS-1:0]   latch_open = '0;
    logic            pi_rev2 = 1'b0;
    logic            busy;
    logic [2:0]      err_code;
    logic            cmd_done;
    logic [2*NS-1:0] slot_state, pwr_ind, attn_ind;
    logic [3:0]      bus_mode;

    int n_vec = 0;
    int n_bad = 0;

    logic [1:0] e_st [NS];
    logic [1:0] e_pw [NS];
    logic [1:0] e_at [NS];
    logic [3:0] e_mode;

    always #2.5 clk = ~clk;

    hpcmd_engine #(.NSLOT(NS), .EXEC_CYC(EX)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .evt_clr(evt_clr), .latch_open(latch_open), .pi_rev2(pi_rev2),
        .busy(busy), .err_code(err_code), .cmd_done(cmd_done),
        .slot_state(slot_state), .pwr_ind(pwr_ind), .attn_ind(attn_ind),
        .bus_mode(bus_mode)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_slots(input string req);
        for (int i = 0; i < NS; i++) begin
            chk(slot_state[2*i +: 2] == e_st[i], req, $sformatf("slot%0d state", i),
                int'(slot_state[2*i +: 2]), int'(e_st[i]));
            chk(pwr_ind[2*i +: 2] == e_pw[i], req, $sformatf("slot%0d power ind", i),
                int'(pwr_ind[2*i +: 2]), int'(e_pw[i]));
            chk(attn_ind[2*i +: 2] == e_at[i], req, $sformatf("slot%0d attn ind", i),
                int'(attn_ind[2*i +: 2]), int'(e_at[i]));
        end
        chk(bus_mode == e_mode, req, "bus_mode", int'(bus_mode), int'(e_mode));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NS; i++) begin
            e_st[i] = 2'b11; e_pw[i] = 2'b11; e_at[i] = 2'b11;
        end
        e_mode = 4'd0;
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(err_code == 3'b000, "R1", "err after reset", int'(err_code), 0);
        chk(cmd_done == 1'b0, "R1", "done after reset", int'(cmd_done), 0);
        chk_slots("R1");
    endtask

    // Expected result of one command, from the requirements
    task automatic model_cmd(input logic [7:0] op, input logic [7:0] tgt,
                             output logic [2:0] er, output string req);
        er = 3'b000;
        if (op < 8'h40) begin
            if (tgt == 8'd0 || tgt > 8'(NS)) begin
                er = 3'b010; req = "R5";
            end else begin
                int s;
                s = int'(tgt) - 1;
                if ((op[1:0] == 2'b01 || op[1:0] == 2'b10) && latch_open[s]) begin
                    er = 3'b001; req = "R6";
                end else begin
                    req = "R4";
                    if (op[1:0] != 2'b00) e_st[s] = op[1:0];
                    if (op[3:2] != 2'b00) e_pw[s] = op[3:2];
                    if (op[5:4] != 2'b00) e_at[s] = op[5:4];
                end
            end
        end else if (op <= 8'h44) begin
            req = "R7"; e_mode = 4'(op - 8'h40);
        end else if (op <= 8'h47) begin
            req = "R7"; er = 3'b010;
        end else if (op == 8'h48 || op == 8'h49) begin
            req = "R8";
            for (int i = 0; i < NS; i++)
                if (!latch_open[i]) e_st[i] = (op == 8'h48) ? 2'b01 : 2'b10;
        end else if (op < 8'h50) begin
            req = "R10"; er = 3'b010;
        end else if (op <= 8'h5D) begin
            req = "R9";
            if (pi_rev2) e_mode = 4'(op - 8'h50);
            else er = 3'b100;
        end else if (op <= 8'h5F) begin
            req = "R9"; er = 3'b010;
        end else begin
            req = "R10"; er = 3'b010;
        end
    endtask

    task automatic issue(input logic [7:0] op, input logic [7:0] tgt,
                         input bit poke, input bit clr_same);
        logic [2:0] er;
        string req;
        @(negedge clk);
        cmd_wr = 1'b1; cmd_wdata = {tgt, op};
        @(negedge clk);
        cmd_wr = 1'b0;
        chk(busy == 1'b1, "R2", "busy after accept", int'(busy), 1);
        chk(err_code == 3'b000, "R11", "err while running", int'(err_code), 0);
        if (poke) begin
            cmd_wr = 1'b1; cmd_wdata = {~tgt, ~op};
        end
        for (int k = 1; k < EX; k++) begin
            @(negedge clk);
            cmd_wr = 1'b0;
            if (k == EX - 1) begin
                chk(busy == 1'b1, "R2", "busy in last cycle", int'(busy), 1);
                evt_clr = clr_same;
            end
        end
        @(negedge clk);
        evt_clr = 1'b0;
        model_cmd(op, tgt, er, req);
        chk(busy == 1'b0, "R2", "busy after EXEC_CYC", int'(busy), 0);
        chk(err_code == er, poke ? "R3" : req, $sformatf("err op %02h tgt %0d", op, tgt),
            int'(err_code), int'(er));
        chk(cmd_done == 1'b1, "R11", "done at completion", int'(cmd_done), 1);
        chk_slots(poke ? "R3" : req);
        evt_clr = 1'b1;
        @(negedge clk);
        evt_clr = 1'b0;
        chk(cmd_done == 1'b0, "R11", "done after clear", int'(cmd_done), 0);
        chk(err_code == er, "R11", "err held", int'(err_code), int'(er));
    endtask

    initial begin
        int cnt;
        cnt = 0;
        for (int cfg = 0; cfg < 4; cfg++) begin
            pi_rev2    = cfg[0];
            latch_open = cfg[1] ? 4'b1010 : 4'b0000;
            do_reset();
            for (int op = 0; op < 256; op++) begin
                if (op < 8'h40) begin
                    for (int t = 0; t <= NS + 1; t++) begin
                        cnt++;
                        issue(8'(op), 8'(t), (cnt % 7) == 0, (cnt % 5) == 0);
                    end
                end else begin
                    cnt++;
                    issue(8'(op), (cnt % 2) ? 8'd1 : 8'hFF, (cnt % 7) == 0, (cnt % 5) == 0);
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule